// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Overrun Hold

This block receives bytes over a synchronous serial link made of a serial clock and a data line. Both lines are brought into the system clock domain through a short synchroniser. On each detected rising edge of the serial clock, one data bit is taken into a shift register. Bits arrive least significant first. After eight bits the byte is complete, and it is offered to a holding data register that the host reads.

A ready flag shows that the holding register has an unread byte. If a byte completes while that flag is still set, the holding register keeps the older byte and an overrun flag is raised. While the overrun flag is set, the receiver takes no further bits, and the host must clear the flag to restart reception.

The host sees the flags and two level interrupt requests: one for received data and one for receive errors. Both are gated by one interrupt enable. The host clears the ready flag either with a dedicated strobe or by pulsing the read strobe. The overrun flag has its own clear strobe.

Top module: `csr_rx_top`

## Requirements
- R1: Bits are assembled least significant first: the first bit sampled after the frame starts ends up in bit 0 of the stored byte.
- R2: When the eighth bit is taken and the ready flag is 0, the byte is written to the holding register and the ready flag becomes 1. This happens three system clocks after the rising serial clock edge reaches the input.
- R3: When a frame completes while the ready flag is 1 and no ready clear occurs in that cycle, the overrun flag becomes 1. The ready flag stays 1, and the holding register keeps its earlier byte.
- R4: The data interrupt output is a level signal equal to ready AND interrupt enable. It falls in the cycle after the ready flag is cleared.
- R5: The error interrupt output is a level signal equal to overrun AND interrupt enable.
- R6: While the overrun flag is 1, serial bits are discarded and any partial frame is dropped. After the overrun clear strobe, reception restarts with a fresh frame.
- R7: The ready flag is cleared by the ready-clear strobe or by the read strobe. The overrun flag is cleared only by its own strobe, so a read leaves it set.
- R8: Driving the receive enable low aborts a partial frame and restarts bit counting. The holding register and both flags keep their values.
- R9: If a frame completes in the same cycle as a ready clear or read strobe, the new byte is loaded, the ready flag stays 1 and no overrun is raised.
- R10: After reset the holding register, both flags and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sdata_i | input | 1 | Serial data, valid at the rising serial clock edge |
| rx_en_i | input | 1 | Receive enable |
| rie_i | input | 1 | Interrupt enable for both requests |
| rd_i | input | 1 | Host read strobe for the holding register, clears ready |
| clr_rdy_i | input | 1 | Ready flag clear strobe |
| clr_ovr_i | input | 1 | Overrun flag clear strobe |
| rdata_o | output | 8 | Holding register contents |
| ready_o | output | 1 | Ready flag |
| ovr_o | output | 1 | Overrun flag |
| rxi_o | output | 1 | Data interrupt request |
| eri_o | output | 1 | Error interrupt request |

## Verification
Frame completion and a host ready clear can land on the same system clock cycle. The rule is that the clear consumes the old byte and the new byte is loaded with no overrun. The bench provokes this by placing a one-cycle ready clear exactly in the cycle where the synchronised final serial edge is detected, two system clocks after the edge is driven. It then checks that the holding register carries the new byte, that ready is still 1 and that the overrun flag stayed 0. A clear landing one cycle too late would instead leave the old byte and raise an overrun.

// File: rtl/csr_pkg.sv
package csr_pkg;
  parameter int unsigned CSR_DATA_W = 8;
  parameter int unsigned CSR_SYNC_N = 2;
endpackage

// File: rtl/csr_sync.sv
module csr_sync #(
  parameter int unsigned STAGES = csr_pkg::CSR_SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic bit_o
);
  logic [STAGES:0]   clk_q;
  logic [STAGES-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= '0;
      dat_q <= '0;
    end else begin
      clk_q <= {clk_q[STAGES-1:0], sclk_i};
      dat_q <= {dat_q[STAGES-2:0], sdata_i};
    end
  end

  // data path has the same depth as the clock path, so the bit lines up with the edge
  assign rise_o = clk_q[STAGES-1] & ~clk_q[STAGES];
  assign bit_o  = dat_q[STAGES-1];
endmodule

// File: rtl/csr_shift.sv
module csr_shift #(
  parameter int unsigned W = csr_pkg::CSR_DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         rise_i,
  input  logic         bit_i,
  output logic         done_o,
  output logic [W-1:0] frame_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic [W-1:0]  sh_d;
  logic          last;

  assign sh_d = {bit_i, sh_q[W-1:1]};  // LSB first: earliest bit drifts down to bit 0
  assign last = (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (rise_i) begin
      sh_q  <= sh_d;
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign done_o  = en_i & rise_i & last;
  assign frame_o = sh_d;

  assert_abort_cnt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  assert_frame_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cnt_q == '0);
endmodule

// File: rtl/csr_hold.sv
module csr_hold #(
  parameter int unsigned W = csr_pkg::CSR_DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  logic [W-1:0] frame_i,
  input  logic         rd_i,
  input  logic         clr_rdy_i,
  input  logic         clr_ovr_i,
  output logic [W-1:0] data_o,
  output logic         ready_o,
  output logic         ovr_o
);
  logic [W-1:0] data_q;
  logic         ready_q;
  logic         ovr_q;
  logic         rdy_clr;
  logic         slot_free;

  assign rdy_clr   = rd_i | clr_rdy_i;
  assign slot_free = ~ready_q | rdy_clr;  // a same-cycle clear consumes the old byte

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ready_q <= 1'b0;
    end else if (done_i && slot_free) begin
      data_q  <= frame_i;
      ready_q <= 1'b1;
    end else if (rdy_clr) begin
      ready_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovr_q <= 1'b0;
    else if (done_i && !slot_free) ovr_q <= 1'b1;
    else if (clr_ovr_i)            ovr_q <= 1'b0;
  end

  assign data_o  = data_q;
  assign ready_o = ready_q;
  assign ovr_o   = ovr_q;

  assert_load_sets_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ready_q |=> ready_q && data_q == $past(frame_i));
  assert_overrun_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && ready_q && !rdy_clr |=> ovr_q && ready_q && $stable(data_q));
  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !clr_ovr_i |=> ovr_q);
  assert_same_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && ready_q && rdy_clr && !ovr_q && !clr_ovr_i |=> ready_q && !ovr_q);
endmodule

// File: rtl/csr_rx_top.sv
module csr_rx_top #(
  parameter int unsigned DATA_W = csr_pkg::CSR_DATA_W,
  parameter int unsigned SYNC_N = csr_pkg::CSR_SYNC_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              rx_en_i,
  input  logic              rie_i,
  input  logic              rd_i,
  input  logic              clr_rdy_i,
  input  logic              clr_ovr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              ovr_o,
  output logic              rxi_o,
  output logic              eri_o
);
  logic              rise;
  logic              sbit;
  logic              shift_en;
  logic              done;
  logic [DATA_W-1:0] frame;

  csr_sync #(.STAGES(SYNC_N)) sync_i (
    .clk_i, .rst_ni, .sclk_i, .sdata_i,
    .rise_o(rise), .bit_o(sbit)
  );

  // halt on error: an overrun flushes and freezes the shifter
  assign shift_en = rx_en_i & ~ovr_o;

  csr_shift #(.W(DATA_W)) shift_i (
    .clk_i, .rst_ni, .en_i(shift_en), .rise_i(rise), .bit_i(sbit),
    .done_o(done), .frame_o(frame)
  );

  csr_hold #(.W(DATA_W)) hold_i (
    .clk_i, .rst_ni, .done_i(done), .frame_i(frame),
    .rd_i, .clr_rdy_i, .clr_ovr_i,
    .data_o(rdata_o), .ready_o, .ovr_o
  );

  assign rxi_o = ready_o & rie_i;
  assign eri_o = ovr_o & rie_i;

  assert_rxi_falls_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && (rd_i || clr_rdy_i) && !done |=> !rxi_o);
  assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !clr_ovr_i |=> $stable(rdata_o));
  assert_eri_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eri_o |-> ovr_o);
endmodule

// File: tb/csr_rx_top_tb_top.sv
module csr_rx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdata = 1'b0, rx_en = 1'b0, rie = 1'b0;
  logic       rd = 1'b0, clr_rdy = 1'b0, clr_ovr = 1'b0;
  logic [7:0] rdata;
  logic       ready, ovr, rxi, eri;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  csr_rx_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .rx_en_i(rx_en), .rie_i(rie), .rd_i(rd), .clr_rdy_i(clr_rdy),
    .clr_ovr_i(clr_ovr), .rdata_o(rdata), .ready_o(ready), .ovr_o(ovr),
    .rxi_o(rxi), .eri_o(eri)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // n bits of v, LSB first; optional ready clear aligned with detection of the last edge
  task automatic send_bits(input logic [7:0] v, input int n, input bit clr_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sdata = v[i]; sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      if (clr_last && i == n - 1) begin
        @(negedge clk);
        @(negedge clk); clr_rdy = 1'b1;
        @(negedge clk); clr_rdy = 1'b0;
        repeat (2) @(negedge clk);
      end else begin
        repeat (4) @(negedge clk);
      end
    end
    @(negedge clk); sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 data", rdata, 8'h00);
    chk("R10 ready", ready, 0);
    chk("R10 ovr", ovr, 0);
    chk("R10 rxi", rxi, 0);
    chk("R10 eri", eri, 0);
  endtask

  task automatic t_basic();
    send_bits(8'hA5, 8, 0);
    chk("R2 data", rdata, 8'hA5);
    chk("R2 ready", ready, 1);
    chk("R4 rxi", rxi, 1);
    chk("R5 eri idle", eri, 0);
    pulse(rd);
    chk("R7 read clears ready", ready, 0);
    chk("R4 rxi falls", rxi, 0);
    send_bits(8'h80, 8, 0);
    chk("R1 lsb first", rdata, 8'h80);
  endtask

  task automatic t_overrun();
    send_bits(8'h3C, 8, 0);
    chk("R3 data kept", rdata, 8'h80);
    chk("R3 ready", ready, 1);
    chk("R3 ovr", ovr, 1);
    chk("R5 eri", eri, 1);
    pulse(rd);
    chk("R7 read leaves ovr", ovr, 1);
    chk("R7 read clears ready", ready, 0);
    send_bits(8'h5A, 8, 0);
    chk("R6 frozen data", rdata, 8'h80);
    chk("R6 frozen ready", ready, 0);
    pulse(clr_ovr);
    chk("R7 ovr clear", ovr, 0);
    chk("R5 eri falls", eri, 0);
    send_bits(8'hC3, 8, 0);
    chk("R6 resume data", rdata, 8'hC3);
    chk("R6 resume ready", ready, 1);
  endtask

  task automatic t_gate();
    @(negedge clk); rie = 1'b0;
    @(negedge clk);
    chk("R4 rxi gated", rxi, 0);
    send_bits(8'h11, 8, 0);
    chk("R5 ovr set", ovr, 1);
    chk("R5 eri gated", eri, 0);
    pulse(clr_ovr);
    pulse(clr_rdy);
    chk("R7 clr strobe", ready, 0);
    @(negedge clk); rie = 1'b1;
  endtask

  task automatic t_abort();
    send_bits(8'hFF, 3, 0);
    @(negedge clk); rx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 data kept", rdata, 8'hC3);
    chk("R8 ready kept", ready, 0);
    rx_en = 1'b1;
    @(negedge clk);
    send_bits(8'h96, 8, 0);
    chk("R8 fresh frame", rdata, 8'h96);
    chk("R8 ovr clear", ovr, 0);
  endtask

  task automatic t_same_cycle();
    send_bits(8'h4B, 8, 1);
    chk("R9 new byte", rdata, 8'h4B);
    chk("R9 ready", ready, 1);
    chk("R9 no overrun", ovr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); rx_en = 1'b1; rie = 1'b1;
    @(negedge clk);
    t_basic();
    t_overrun();
    t_gate();
    t_abort();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule